// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit half of the descriptor machinery in a 10/100 Ethernet MAC. It keeps four descriptor slots as plain registers. Each slot has a buffer address word, a length word and a status word. Software fills a slot's length, then writes its buffer address with the enable flag set. That hands the slot to the engine. The engine visits the slots in a fixed circular order. For each armed slot it reads the buffer one byte at a time through a request/acknowledge memory port. It passes each byte to the frame sink over a valid/ready handshake, with a last marker on the final byte. After the last byte it waits for the sink's one-cycle completion report. It then copies that report into the slot's status word, marks the slot done and disarms it.

Buffers sit on 2 KB boundaries, so the low eleven bits of each address word are free for control flags. Every address word also shows the index of the slot the engine will serve next, so software can line its own ring pointer up with the engine's after reset. Software acknowledges a finished slot by writing its address word, which clears the done flag.

The engine is a five-state machine: `ST_IDLE` (waiting for the current slot to be armed), `ST_FETCH` (memory read outstanding), `ST_SEND` (byte offered to the sink), `ST_WAIT_CPL` (waiting for the completion report) and `ST_POST` (status written back, slot index advanced). Its transitions are:

- idle→fetch: the slot is armed with a non-zero length.
- idle→post: the slot is armed with length zero.
- fetch→send: the memory acknowledges.
- send→fetch: a byte other than the last is accepted.
- send→wait_cpl: the last byte is accepted.
- wait_cpl→post: the completion report arrives.
- post→idle: always.

Top module: `txdesc_ring_engine`

## Requirements
- R1: After a synchronous active-high reset, every slot register reads zero, the next-slot index is 0, and neither `mem_req` nor `tx_valid` is asserted.
- R2: Register select is `reg_addr[3:2]` = slot and `reg_addr[1:0]` = word, where 0 = address, 1 = length and 2 = status; word 3 reads zero. Address word: bit 0 = enable, bit 1 = done, bits 3:2 = next-slot index (read-only, the same in every slot), bits 31:11 = buffer base, bits 10:4 read zero. Length word: bits 10:0. Status word: bit 0 = frame aborted, bit 1 = excessive collisions, bits 7:4 = collision count, all other bits zero.
- R3: Slots are served strictly in the order 0,1,2,3,0,... The engine stalls on the current slot while its enable bit is clear, even when a later slot is armed.
- R4: A frame of length L is read from byte addresses base+0 … base+L−1 in order, one memory read per byte. Exactly L bytes reach the sink, and `tx_last` is set on the final byte only. `tx_data` and `tx_last` stay steady while `tx_valid` is high and `tx_ready` is low. A memory request holds its address until acknowledged.
- R5: After the last byte is accepted, the engine issues no further request until `cpl_valid` arrives. It then writes the reported flags and count into the slot's status word, sets done, clears enable and advances the next-slot index.
- R6: An armed slot of length zero completes with no memory read, no byte to the sink and no wait for a completion report, and its status word is zero.
- R7: Any write to an address word stores the base and the enable bit and clears done. Any write to a status word clears it to zero whatever the data. Enable and done are never both set.
- R8: The engine captures base and length when a frame starts. Writes to that slot during the frame change the readable registers but not the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Slot (bits 3:2) and word select (bits 1:0) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Buffer byte read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_ack | input | 1 | Read accepted, `mem_rdata` valid |
| mem_rdata | input | 8 | Byte read from the buffer |
| tx_valid | output | 1 | Frame byte offered to the sink |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| cpl_valid | input | 1 | One-cycle completion report from the sink |
| cpl_abort | input | 1 | Frame was aborted |
| cpl_excol | input | 1 | Excessive collisions |
| cpl_ccount | input | 4 | Collision count |

## Verification
The main path is driven with frames of several lengths (five, four, three, two, six bytes and zero), taken from different 2 KB pages. The memory acknowledge and sink ready patterns stall at different rates, so the checks separate correct addressing and byte order from dropped or repeated bytes under backpressure. One armed slot behind a disarmed one shows whether the engine skips ahead. A sequence that wraps from slot 3 to slot 0 through a zero-length slot tests the index wrap and the empty-frame shortcut. Distinct completion reports per frame show that each status lands in its own slot. Rewriting a slot in mid-frame separates captured values from live register values.

// File: rtl/txr_pkg.sv
package txr_pkg;

    // Engine states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_WAIT_CPL,
        ST_POST
    } eng_state_e;

    // Word select within a slot
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Flag positions in the address word
    localparam int EN_BIT   = 0;
    localparam int DONE_BIT = 1;

    // Status word layout (bits 7:0)
    typedef struct packed {
        logic [3:0] ccount;
        logic [1:0] rsvd;
        logic       excol;
        logic       abort;
    } tx_stat_t;

endpackage

// File: rtl/txr_slot.sv
module txr_slot
    import txr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 11,
    parameter int LEN_W  = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_addr,
    input  logic                    wr_len,
    input  logic                    wr_stat,
    input  logic [ADDR_W-1:0]       wdata,
    input  logic                    post,
    input  tx_stat_t                post_stat,
    output logic [ADDR_W-OFF_W-1:0] base,
    output logic                    en,
    output logic                    done,
    output logic [LEN_W-1:0]        len,
    output tx_stat_t                stat
);

    // Address word and status: the engine's post wins over software
    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            en   <= 1'b0;
            done <= 1'b0;
            stat <= '0;
        end else if (post) begin
            en   <= 1'b0;
            done <= 1'b1;
            stat <= post_stat;
        end else begin
            if (wr_addr) begin
                base <= wdata[ADDR_W-1:OFF_W];
                en   <= wdata[EN_BIT];
                done <= 1'b0;
            end
            if (wr_stat) begin
                stat <= '0;
            end
        end
    end

    // Length word: software only
    always_ff @(posedge clk) begin
        if (rst) begin
            len <= '0;
        end else if (wr_len) begin
            len <= wdata[LEN_W-1:0];
        end
    end

endmodule

// File: rtl/txr_slot_bank.sv
module txr_slot_bank
    import txr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2,
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 11,
    parameter int LEN_W     = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_we,
    input  logic [SLOT_W+1:0]       reg_addr,
    input  logic [ADDR_W-1:0]       reg_wdata,
    output logic [ADDR_W-1:0]       reg_rdata,
    input  logic [SLOT_W-1:0]       cur_slot,
    input  logic                    post,
    input  tx_stat_t                post_stat,
    output logic [ADDR_W-OFF_W-1:0] sel_base,
    output logic                    sel_en,
    output logic [LEN_W-1:0]        sel_len,
    output logic [NUM_SLOTS-1:0]    en_vec,
    output logic [NUM_SLOTS-1:0]    done_vec
);

    localparam int BASE_W = ADDR_W - OFF_W;
    localparam int PAD_W  = OFF_W - 2 - SLOT_W;

    logic [SLOT_W-1:0] acc_slot;
    reg_sel_e          acc_sel;
    logic [BASE_W-1:0] base_a [NUM_SLOTS];
    logic [LEN_W-1:0]  len_a  [NUM_SLOTS];
    tx_stat_t          stat_a [NUM_SLOTS];

    assign acc_slot = reg_addr[SLOT_W+1:2];
    assign acc_sel  = reg_sel_e'(reg_addr[1:0]);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = reg_we && (acc_slot == SLOT_W'(g));

        txr_slot #(
            .ADDR_W(ADDR_W),
            .OFF_W (OFF_W),
            .LEN_W (LEN_W)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_addr  (hit && (acc_sel == SEL_ADDR)),
            .wr_len   (hit && (acc_sel == SEL_LEN)),
            .wr_stat  (hit && (acc_sel == SEL_STAT)),
            .wdata    (reg_wdata),
            .post     (post && (cur_slot == SLOT_W'(g))),
            .post_stat(post_stat),
            .base     (base_a[g]),
            .en       (en_vec[g]),
            .done     (done_vec[g]),
            .len      (len_a[g]),
            .stat     (stat_a[g])
        );
    end

    // Fields of the slot the engine is looking at
    assign sel_base = base_a[cur_slot];
    assign sel_en   = en_vec[cur_slot];
    assign sel_len  = len_a[cur_slot];

    // Read mux
    always_comb begin
        unique case (acc_sel)
            SEL_ADDR: reg_rdata = {base_a[acc_slot], {PAD_W{1'b0}}, cur_slot,
                                   done_vec[acc_slot], en_vec[acc_slot]};
            SEL_LEN:  reg_rdata = ADDR_W'(len_a[acc_slot]);
            SEL_STAT: reg_rdata = ADDR_W'(stat_a[acc_slot]);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2,
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 11,
    parameter int LEN_W     = 11,
    parameter int BYTE_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel_en,
    input  logic [ADDR_W-OFF_W-1:0] sel_base,
    input  logic [LEN_W-1:0]        sel_len,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_ack,
    input  logic [BYTE_W-1:0]       mem_rdata,
    output logic                    tx_valid,
    output logic [BYTE_W-1:0]       tx_data,
    output logic                    tx_last,
    input  logic                    tx_ready,
    input  logic                    cpl_valid,
    input  tx_stat_t                cpl_stat,
    output logic                    post,
    output tx_stat_t                post_stat,
    output logic [SLOT_W-1:0]       cur_slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    eng_state_e                state, nxt;
    logic [ADDR_W-OFF_W-1:0]   base_q;
    logic [LEN_W-1:0]          len_q;
    logic [LEN_W-1:0]          cnt;
    logic [BYTE_W-1:0]         byte_q;
    tx_stat_t                  stat_q;
    logic                      last_byte;

    assign last_byte = (cnt == len_q - 1'b1);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sel_en) begin
                    nxt = (sel_len == '0) ? ST_POST : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    nxt = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    nxt = last_byte ? ST_WAIT_CPL : ST_FETCH;
                end
            end
            ST_WAIT_CPL: begin
                if (cpl_valid) begin
                    nxt = ST_POST;
                end
            end
            ST_POST: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        post      = 1'b0;
        unique case (state)
            ST_FETCH: mem_req = 1'b1;
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_last  = last_byte;
            end
            ST_POST: post = 1'b1;
            default: ;
        endcase
        mem_addr  = {base_q, cnt};
        tx_data   = byte_q;
        post_stat = stat_q;
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            len_q    <= '0;
            cnt      <= '0;
            byte_q   <= '0;
            stat_q   <= '0;
            cur_slot <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sel_en) begin
                        base_q <= sel_base;
                        len_q  <= sel_len;
                        cnt    <= '0;
                        stat_q <= '0;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        byte_q <= mem_rdata;
                    end
                end
                ST_SEND: begin
                    if (tx_ready) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT_CPL: begin
                    if (cpl_valid) begin
                        stat_q <= cpl_stat;
                    end
                end
                ST_POST: begin
                    cur_slot <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/txdesc_ring_engine.sv
module txdesc_ring_engine
    import txr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 2048,
    parameter int BYTE_W    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [7:0]  mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic        cpl_valid,
    input  logic        cpl_abort,
    input  logic        cpl_excol,
    input  logic [3:0]  cpl_ccount
);

    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int OFF_W  = $clog2(BUF_BYTES);
    localparam int LEN_W  = OFF_W;

    logic [SLOT_W-1:0]       cur_slot;
    logic [NUM_SLOTS-1:0]    en_vec;
    logic [NUM_SLOTS-1:0]    done_vec;
    logic                    post;
    tx_stat_t                post_stat;
    tx_stat_t                cpl_stat;
    logic [ADDR_W-OFF_W-1:0] sel_base;
    logic                    sel_en;
    logic [LEN_W-1:0]        sel_len;

    always_comb begin
        cpl_stat.ccount = cpl_ccount;
        cpl_stat.rsvd   = 2'b00;
        cpl_stat.excol  = cpl_excol;
        cpl_stat.abort  = cpl_abort;
    end

    txr_slot_bank #(
        .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W   (SLOT_W),
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .LEN_W    (LEN_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cur_slot (cur_slot),
        .post     (post),
        .post_stat(post_stat),
        .sel_base (sel_base),
        .sel_en   (sel_en),
        .sel_len  (sel_len),
        .en_vec   (en_vec),
        .done_vec (done_vec)
    );

    txr_engine #(
        .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W   (SLOT_W),
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .LEN_W    (LEN_W),
        .BYTE_W   (BYTE_W)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .sel_en   (sel_en),
        .sel_base (sel_base),
        .sel_len  (sel_len),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .cpl_valid(cpl_valid),
        .cpl_stat (cpl_stat),
        .post     (post),
        .post_stat(post_stat),
        .cur_slot (cur_slot)
    );

endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2,
    parameter int ADDR_W    = 32,
    parameter int BYTE_W    = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tx_valid,
    input logic                 tx_ready,
    input logic [BYTE_W-1:0]    tx_data,
    input logic                 tx_last,
    input logic                 mem_req,
    input logic                 mem_ack,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [SLOT_W-1:0]    cur_slot,
    input logic [NUM_SLOTS-1:0] en_vec,
    input logic [NUM_SLOTS-1:0] done_vec
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] cur_prev;
    logic [SLOT_W-1:0] cur_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_prev <= '0;
        end else begin
            cur_prev <= cur_slot;
        end
    end

    assign cur_step = (cur_prev == LAST_SLOT) ? '0 : cur_prev + 1'b1;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!tx_valid && !mem_req && cur_slot == '0));

    assert_slot_order_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_slot != cur_prev) |-> (cur_slot == cur_step));

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_one_side_R4: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && mem_req));

    assert_wait_cpl_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> (!tx_valid && !mem_req));

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_chk
        assert_done_disarms_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(done_vec[i]) |-> !en_vec[i]);

        assert_en_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
            !(en_vec[i] && done_vec[i]));
    end

endmodule

bind txdesc_ring_engine txr_checker #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W),
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_data (tx_data),
    .tx_last (tx_last),
    .mem_req (mem_req),
    .mem_ack (mem_ack),
    .mem_addr(mem_addr),
    .cur_slot(cur_slot),
    .en_vec  (en_vec),
    .done_vec(done_vec)
);

// File: tb/txdesc_ring_engine_tb.sv
module txdesc_ring_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b0;
    logic        cpl_valid = 1'b0;
    logic        cpl_abort = 1'b0;
    logic        cpl_excol = 1'b0;
    logic [3:0]  cpl_ccount = '0;

    always #10 clk = ~clk;

    txdesc_ring_engine u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready),
        .cpl_valid (cpl_valid),
        .cpl_abort (cpl_abort),
        .cpl_excol (cpl_excol),
        .cpl_ccount(cpl_ccount)
    );

    int total = 0;
    int bad   = 0;
    int phase = 0;
    int ncap  = 0;
    int cpl_delay = 0;
    logic [7:0] capt_data [64];
    logic       capt_last [64];
    logic       cfg_abort = 1'b0;
    logic       cfg_excol = 1'b0;
    logic [3:0] cfg_cc    = '0;

    localparam logic [31:0] B0 = 32'h0001_0800;
    localparam logic [31:0] B1 = 32'h0002_3000;
    localparam logic [31:0] B2 = 32'h0004_5800;
    localparam logic [31:0] B3 = 32'h0000_8000;
    localparam logic [31:0] B4 = 32'h0007_F800;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[18:11];
    endfunction

    function automatic logic [3:0] ra(input int s, input int sel);
        return 4'(s * 4 + sel);
    endfunction

    // Memory responder, frame sink and completion reporter (all at negedge)
    always @(negedge clk) begin
        phase++;
        cpl_valid = 1'b0;
        if (cpl_delay > 0) begin
            cpl_delay--;
            if (cpl_delay == 0) begin
                cpl_valid  = 1'b1;
                cpl_abort  = cfg_abort;
                cpl_excol  = cfg_excol;
                cpl_ccount = cfg_cc;
            end
        end
        mem_ack   = mem_req && (phase % 3 != 0);
        mem_rdata = mem_byte(mem_addr);
        tx_ready  = (phase % 4 != 1);
        if (tx_valid && tx_ready) begin
            if (ncap < 64) begin
                capt_data[ncap] = tx_data;
                capt_last[ncap] = tx_last;
            end
            ncap++;
            if (tx_last) cpl_delay = 3;
        end
    end

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done(input int s, input string req);
        logic [31:0] v;
        bit got;
        got = 1'b0;
        v = '0;
        for (int k = 0; k < 3000 && !got; k++) begin
            rd(ra(s, 0), v);
            got = v[1];
        end
        chk_eq(req, 32'(got), 32'd1);
    endtask

    task automatic check_frame(input int start, input logic [31:0] base, input int len, input string req);
        for (int i = 0; i < len; i++) begin
            chk_eq(req, 32'(capt_data[start + i]), 32'(mem_byte(base + 32'(i))));
            chk_eq(req, 32'(capt_last[start + i]), 32'(i == len - 1));
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 3; w++) begin
                rd(ra(s, w), v);
                chk_eq("R1 register after reset", v, 32'h0);
            end
        end
        chk_eq("R1 no request after reset", 32'({mem_req, tx_valid}), 32'h0);
    endtask

    // R2 R4 R5: one frame on slot 0
    task automatic t_single();
        logic [31:0] v;
        ncap = 0;
        cfg_abort = 1'b0; cfg_excol = 1'b0; cfg_cc = 4'd3;
        wr(ra(0, 1), 32'd5);
        wr(ra(0, 0), B0 | 32'h1);
        wait_done(0, "R5 slot0 done");
        chk_eq("R4 byte count", 32'(ncap), 32'd5);
        check_frame(0, B0, 5, "R4 slot0 bytes");
        rd(ra(0, 0), v);
        chk_eq("R2 R5 slot0 address word", v, B0 | 32'h6);
        rd(ra(0, 2), v);
        chk_eq("R2 R5 slot0 status", v, 32'h30);
        rd(ra(0, 1), v);
        chk_eq("R2 slot0 length", v, 32'd5);
    endtask

    // R3: stall on disarmed slot 1 while slot 2 is armed
    task automatic t_stall();
        logic [31:0] v;
        ncap = 0;
        cfg_abort = 1'b1; cfg_excol = 1'b1; cfg_cc = 4'd15;
        wr(ra(2, 1), 32'd3);
        wr(ra(2, 0), B2 | 32'h1);
        repeat (60) @(negedge clk);
        chk_eq("R3 no bytes while slot1 disarmed", 32'(ncap), 32'd0);
        rd(ra(2, 0), v);
        chk_eq("R3 slot2 still pending", v, B2 | 32'h5);
        wr(ra(1, 1), 32'd4);
        wr(ra(1, 0), B1 | 32'h1);
        wait_done(2, "R3 slot2 done");
        chk_eq("R3 byte count", 32'(ncap), 32'd7);
        check_frame(0, B1, 4, "R3 slot1 first");
        check_frame(4, B2, 3, "R3 slot2 second");
        rd(ra(2, 2), v);
        chk_eq("R5 slot2 status", v, 32'hF3);
        rd(ra(1, 2), v);
        chk_eq("R5 slot1 status", v, 32'hF3);
        rd(ra(2, 0), v);
        chk_eq("R3 slot2 address word", v, B2 | 32'hE);
    endtask

    // R7: acknowledge and status clear
    task automatic t_ack();
        logic [31:0] v;
        wr(ra(0, 0), 32'h0);
        rd(ra(0, 0), v);
        chk_eq("R7 done cleared by write", v, 32'h0000_000C);
        wr(ra(0, 2), 32'hFFFF_FFFF);
        rd(ra(0, 2), v);
        chk_eq("R7 status cleared by write", v, 32'h0);
        chk_eq("R7 no activity after ack", 32'(ncap), 32'd7);
    endtask

    // R6 and wrap 3 -> 0
    task automatic t_wrap_zero();
        logic [31:0] v;
        ncap = 0;
        cfg_abort = 1'b1; cfg_excol = 1'b0; cfg_cc = 4'd2;
        wr(ra(3, 1), 32'd0);
        wr(ra(3, 0), B3 | 32'h1);
        wr(ra(0, 1), 32'd2);
        wr(ra(0, 0), B0 | 32'h1);
        wait_done(0, "R3 wrap slot0 done");
        chk_eq("R6 only slot0 bytes", 32'(ncap), 32'd2);
        check_frame(0, B0, 2, "R3 slot0 after wrap");
        rd(ra(3, 2), v);
        chk_eq("R6 zero-length status", v, 32'h0);
        rd(ra(3, 0), v);
        chk_eq("R6 zero-length done", v, B3 | 32'h6);
        rd(ra(0, 2), v);
        chk_eq("R5 slot0 status after wrap", v, 32'h21);
    endtask

    // R8: rewrite during a frame
    task automatic t_midframe();
        logic [31:0] v;
        bit seen;
        ncap = 0;
        cfg_abort = 1'b0; cfg_excol = 1'b0; cfg_cc = 4'd1;
        wr(ra(1, 1), 32'd6);
        wr(ra(1, 0), B4 | 32'h1);
        seen = 1'b0;
        for (int k = 0; k < 500 && !seen; k++) begin
            @(negedge clk);
            #1;
            seen = (ncap >= 1);
        end
        wr(ra(1, 1), 32'd2);
        wr(ra(1, 0), B1 | 32'h1);
        wait_done(1, "R8 slot1 done");
        chk_eq("R8 frame length kept", 32'(ncap), 32'd6);
        check_frame(0, B4, 6, "R8 frame base kept");
        rd(ra(1, 1), v);
        chk_eq("R8 length register updated", v, 32'd2);
        rd(ra(1, 0), v);
        chk_eq("R8 address register updated", v, B1 | 32'hA);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_stall();
        t_ack();
        t_wrap_zero();
        t_midframe();
        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule